// File: doc/BRIEF.md
# Dual-Clock On/Off PWM Generator

This block drives a single pulse-width-modulated output from two independent 16-bit phase counts. One count sets the length of the active phase and the other sets the length of the inactive phase. A count of N holds its phase for N+1 timebase ticks, so one period lasts (on+1)+(off+1) ticks. The timebase is either the fast system clock or a slow reference. The slow reference is produced inside the same clock domain as a one-cycle strobe every `SLOW_DIV` fast cycles. Either timebase then passes through a prescaler that divides by any ratio from 1 to 16.

Software uses a small register port to program the block. It writes the on count, the off count and a control word that holds an enable bit, a polarity bit, a timebase select bit and a prescaler field. The expected sequence is to clear enable, change the timing fields and set enable again. Count writes made while the block runs are picked up at the next phase boundary. Two count pairs are reserved to hold the output at a constant level: on=0 with off=1 holds it inactive, and on=1 with off=0 holds it active.

Top module: `pwm_onoff_gen`

## Requirements
- R1: After reset, every register reads 0 and `pwm_o` is 0.
- R2: Address 0 holds the on count and address 1 holds the off count, both full 16-bit. Address 2 holds the control word: bit 0 enable, bit 1 polarity, bit 2 timebase select, bits 7:4 prescaler. A read returns the last value written, with every other control bit reading 0. Address 3 reads 0.
- R3: With the fast timebase and prescaler 0, the active phase lasts on+1 clock cycles and the inactive phase lasts off+1 clock cycles.
- R4: A prescaler value d stretches every phase by a factor of d+1.
- R5: With the timebase select bit set, each tick is `SLOW_DIV` fast cycles before the prescaler applies, so a phase lasts (N+1)*(d+1)*`SLOW_DIV` cycles.
- R6: on=0 with off=1 holds the output at the inactive level with no pulses.
- R7: on=1 with off=0 holds the output at the active level with no pulses.
- R8: With the polarity bit set, the active phase drives 0 and the inactive phase drives 1.
- R9: While enable is 0, the output sits at the inactive level for the current polarity: 0 with polarity clear, 1 with polarity set.
- R10: After enable is set, the output turns active at the first prescaled tick. With the fast timebase and prescaler d, the output is high in the (d+1)-th cycle after the enabling write.
- R11: A count written while the output runs does not change the phase already under way. It applies from the next phase of that kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, also the fast timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pwm_o | output | 1 | PWM output level |

## Verification
The hardest case to reach is a count rewritten in the middle of a running phase. The new value must wait for the phase boundary, but a port-level check only sees phase lengths. The bench programs a long active phase and waits for the output's rising edge. A few cycles later it writes a much shorter on count. It then counts the current high run, which must keep its old length, the low run after it, and the next high run, which must have the new length. Start-up latency is checked cycle by cycle from the enabling write, for two prescaler values.

// File: rtl/pwm_onoff_pkg.sv
package pwm_onoff_pkg;

  localparam int PRE_W = 4;

  localparam logic [1:0] ADDR_ON  = 2'd0;
  localparam logic [1:0] ADDR_OFF = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  // control word bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_POL = 1;
  localparam int CTL_SEL = 2;
  localparam int CTL_PRE_LO = 4;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             slow_sel;
    logic             inv;
    logic             run;
  } ctl_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    LVL_TOGGLE = 2'd0,
    LVL_INACT  = 2'd1,
    LVL_ACT    = 2'd2
  } level_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_onoff_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic [CNT_W-1:0] on_cnt,
  output logic [CNT_W-1:0] off_cnt,
  output ctl_t             ctl
);

  logic [CNT_W-1:0] on_d, off_d;
  ctl_t             ctl_d;

  always_comb begin
    on_d  = on_cnt;
    off_d = off_cnt;
    ctl_d = ctl;
    if (wr_en) begin
      unique case (addr)
        ADDR_ON:  on_d  = wdata;
        ADDR_OFF: off_d = wdata;
        ADDR_CTL: begin
          ctl_d.run      = wdata[CTL_EN];
          ctl_d.inv      = wdata[CTL_POL];
          ctl_d.slow_sel = wdata[CTL_SEL];
          ctl_d.pre      = wdata[CTL_PRE_LO +: PRE_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt  <= '0;
      off_cnt <= '0;
      ctl     <= '0;
    end else if (wr_en) begin
      on_cnt  <= on_d;
      off_cnt <= off_d;
      ctl     <= ctl_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_ON:  rdata = on_cnt;
      ADDR_OFF: rdata = off_cnt;
      ADDR_CTL: begin
        rdata[CTL_EN]             = ctl.run;
        rdata[CTL_POL]            = ctl.inv;
        rdata[CTL_SEL]            = ctl.slow_sel;
        rdata[CTL_PRE_LO +: PRE_W] = ctl.pre;
      end
      default: rdata = '0;
    endcase
  end

  AST_ON_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_ON) |=> on_cnt == $past(wdata)); // R2
  AST_OFF_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_OFF) |=> off_cnt == $past(wdata)); // R2

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_onoff_pkg::*;
#(
  parameter int SLOW_DIV = 480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow_sel,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);

  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic          slow_stb;
  logic          base_en;
  logic [PRE_W-1:0] pre_q, pre_d;

  generate
    if (SLOW_DIV > 1) begin : g_slow
      logic [SW-1:0] slow_q, slow_d;
      assign slow_stb = (slow_q == SW'(SLOW_DIV - 1));

      always_comb begin
        if (!run)          slow_d = '0;
        else if (slow_stb) slow_d = '0;
        else               slow_d = slow_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slow_q <= '0;
        else        slow_q <= slow_d;
      end
    end else begin : g_noslow
      assign slow_stb = 1'b1;
    end
  endgenerate

  assign base_en = slow_sel ? slow_stb : 1'b1;

  always_comb begin
    pre_d = pre_q;
    if (!run)                pre_d = '0;
    else if (base_en) begin
      if (pre_q == pre)      pre_d = '0;
      else                   pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run & base_en & (pre_q == pre);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && (pre != '0 || (slow_sel && SLOW_DIV > 1)))
      |=> (!tick || !$stable(pre) || !$stable(slow_sel))); // R4

endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr
  import pwm_onoff_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] on_cnt,
  input  logic [CNT_W-1:0] off_cnt,
  output logic             active
);

  phase_e           phase_q, phase_d;
  level_e           lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  level_e           lvl_new;

  always_comb begin
    if (on_cnt == CNT_W'(0) && off_cnt == CNT_W'(1))      lvl_new = LVL_INACT;
    else if (on_cnt == CNT_W'(1) && off_cnt == CNT_W'(0)) lvl_new = LVL_ACT;
    else                                                  lvl_new = LVL_TOGGLE;
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    lvl_d   = lvl_q;
    if (!run) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      lvl_d   = LVL_TOGGLE;
    end else if (tick) begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_HIGH;
          cnt_d   = on_cnt;
          lvl_d   = lvl_new;
        end
        PH_HIGH: begin
          if (cnt_q == '0) begin
            phase_d = PH_LOW;
            cnt_d   = off_cnt;
            lvl_d   = lvl_new;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt_q == '0) begin
            phase_d = PH_HIGH;
            cnt_d   = on_cnt;
            lvl_d   = lvl_new;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      lvl_q   <= LVL_TOGGLE;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      lvl_q   <= lvl_d;
    end
  end

  always_comb begin
    active = 1'b0;
    if (run && phase_q != PH_IDLE) begin
      unique case (lvl_q)
        LVL_ACT:   active = 1'b1;
        LVL_INACT: active = 1'b0;
        default:   active = (phase_q == PH_HIGH);
      endcase
    end
  end

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && phase_q == PH_IDLE)
      |=> (phase_q == PH_HIGH && cnt_q == $past(on_cnt))); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && phase_q != PH_IDLE) |=> ($stable(phase_q) && $stable(cnt_q))); // R3
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> phase_q == PH_IDLE); // R9
  AST_MID_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q != '0 && phase_q != PH_IDLE)
      |=> (phase_q == $past(phase_q) && cnt_q == $past(cnt_q) - 1'b1)); // R11

endmodule

// File: rtl/pwm_onoff_gen.sv
module pwm_onoff_gen
  import pwm_onoff_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SLOW_DIV = 480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             pwm_o
);

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic [CNT_W-1:0] on_cnt, off_cnt;
  ctl_t             ctl;
  logic             tick;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .on_cnt  (on_cnt),
    .off_cnt (off_cnt),
    .ctl     (ctl)
  );

  pwm_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (ctl.run),
    .slow_sel (ctl.slow_sel),
    .pre      (ctl.pre),
    .tick     (tick)
  );

  pwm_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run     (ctl.run),
    .tick    (tick),
    .on_cnt  (on_cnt),
    .off_cnt (off_cnt),
    .active  (active)
  );

  assign pwm_o = active ^ ctl.inv;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctl.run |-> pwm_o == ctl.inv); // R9
  AST_STEADY_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl.run && on_cnt == '0 && off_cnt == CNT_W'(1) && $stable(on_cnt)
     && $stable(off_cnt) && $past(pwm_o) == ctl.inv && $stable(ctl.inv))
      |-> pwm_o == ctl.inv); // R6

endmodule

// File: tb/tb_pwm_onoff_gen.sv
module tb_pwm_onoff_gen;

  localparam int CLK_PERIOD = 10;
  localparam int SLOW       = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        pwm_o;

  int n_checks = 0;
  int n_fail   = 0;

  pwm_onoff_gen #(.CNT_W(16), .SLOW_DIV(SLOW)) dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .pwm_o (pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input bit en, input bit pol,
                                      input bit sel, input int pre);
    return {8'h00, 4'(pre), 1'b0, sel, pol, en};
  endfunction

  task automatic setup(input int on, input int off, input logic [15:0] c);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'(on));
    wr(2'd1, 16'(off));
    wr(2'd2, c);
  endtask

  task automatic runs(input logic act, output int hi, output int lo);
    while (pwm_o == act) @(negedge clk);
    while (pwm_o != act) @(negedge clk);
    hi = 0;
    while (pwm_o == act) begin hi++; @(negedge clk); end
    lo = 0;
    while (pwm_o != act) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      check("R1 reg", int'(rdata), 0);
    end
    check("R1 pwm_o", int'(pwm_o), 0);
  endtask

  task automatic t_readback();
    wr(2'd0, 16'hBEEF); wr(2'd1, 16'h1234); wr(2'd2, 16'hFFF0);
    addr = 2'd0; #1; check("R2 on", int'(rdata), 16'hBEEF);
    addr = 2'd1; #1; check("R2 off", int'(rdata), 16'h1234);
    addr = 2'd2; #1; check("R2 ctl", int'(rdata), 16'h00F0);
    addr = 2'd3; #1; check("R2 addr3", int'(rdata), 0);
    check("R9 idle low", int'(pwm_o), 0);
  endtask

  task automatic t_fast();
    int hi, lo;
    setup(3, 5, ctl(1, 0, 0, 0));
    runs(1'b1, hi, lo);
    check("R3 hi", hi, 4); check("R3 lo", lo, 6);
    setup(0, 0, ctl(1, 0, 0, 0));
    runs(1'b1, hi, lo);
    check("R3 hi zero", hi, 1); check("R3 lo zero", lo, 1);
  endtask

  task automatic t_prescale();
    int hi, lo;
    setup(2, 4, ctl(1, 0, 0, 2));
    runs(1'b1, hi, lo);
    check("R4 hi", hi, 9); check("R4 lo", lo, 15);
    setup(0, 2, ctl(1, 0, 0, 15));
    runs(1'b1, hi, lo);
    check("R4 hi max", hi, 16); check("R4 lo max", lo, 48);
  endtask

  task automatic t_slow();
    int hi, lo;
    setup(1, 2, ctl(1, 0, 1, 1));
    runs(1'b1, hi, lo);
    check("R5 hi", hi, 2 * 2 * SLOW); check("R5 lo", lo, 3 * 2 * SLOW);
  endtask

  task automatic t_steady();
    int seen;
    setup(0, 1, ctl(1, 0, 0, 0));
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); seen += int'(pwm_o); end
    check("R6 steady inactive highs", seen, 0);
    setup(1, 0, ctl(1, 0, 0, 0));
    @(negedge clk); @(negedge clk);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); seen += int'(!pwm_o); end
    check("R7 steady active lows", seen, 0);
  endtask

  task automatic t_polarity();
    int hi, lo;
    wr(2'd2, ctl(0, 1, 0, 0));
    @(negedge clk);
    check("R9 idle inverted", int'(pwm_o), 1);
    setup(2, 6, ctl(1, 1, 0, 0));
    runs(1'b0, hi, lo);
    check("R8 active low run", hi, 3); check("R8 inactive high run", lo, 7);
    wr(2'd2, ctl(0, 1, 0, 0));
    check("R9 after disable", int'(pwm_o), 1);
  endtask

  task automatic t_start();
    for (int d = 0; d < 3; d += 2) begin
      setup(4, 4, ctl(1, 0, 0, d));
      for (int n = 1; n <= d; n++) begin
        check("R10 before first tick", int'(pwm_o), 0);
        @(negedge clk);
      end
      check("R10 before first tick", int'(pwm_o), 0);
      @(negedge clk);
      check("R10 first tick high", int'(pwm_o), 1);
    end
  endtask

  task automatic t_midwrite();
    int hi, lo, hi2;
    setup(9, 3, ctl(1, 0, 0, 0));
    while (pwm_o == 1'b1) @(negedge clk);
    while (pwm_o == 1'b0) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 3; i++) begin hi += int'(pwm_o); @(negedge clk); end
    wr_en = 1'b1; addr = 2'd0; wdata = 16'd2;
    hi += int'(pwm_o); @(negedge clk);
    wr_en = 1'b0;
    while (pwm_o == 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (pwm_o == 1'b0) begin lo++; @(negedge clk); end
    hi2 = 0;
    while (pwm_o == 1'b1) begin hi2++; @(negedge clk); end
    check("R11 phase in progress kept", hi, 10);
    check("R11 off phase", lo, 4);
    check("R11 new count applied", hi2, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_fast();
    t_prescale();
    t_slow();
    t_steady();
    t_polarity();
    t_start();
    t_midwrite();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule